// File: doc/BRIEF.md
# Vibrato-aware FM operator phase generator

This block advances the phase accumulators of the four operators of one FM synthesis channel. Each operator takes a 14-bit frequency word. The word holds a 3-bit octave field in bits [13:11] and an 11-bit frequency number in bits [10:0]. From this word the block forms a per-sample phase increment and adds it to the operator's 20-bit accumulator on a one-cycle sample strobe. The increment is combinational. The accumulators are registered, so the phase read during a sample is the value before that sample's update.

Vibrato is applied as a signed per-operator offset. An external depth table supplies it, using the row address this block exposes (frequency-number bits [10:4] of each operator's word). The offset acts on the frequency number at 12-bit precision and never changes the octave field. The keyscale code that indexes the external detune table is taken straight from the stored code, so vibrato cannot change it. Each detune value is looked up outside the block and comes in already resolved.

In the channel's split-frequency mode the operators take separate frequency words in a fixed, non-sequential order. All four operators still share one keyscale code and one sensitivity setting.

Top module: `fm_phase_gen`

## Requirements
- R1: While `rst_n` is low, all four accumulators are cleared to zero on the clock edge.
- R2: On a cycle with `sample_stb` low, every accumulator holds its value. On a cycle with it high, each accumulator takes its old value plus its increment, and the new value is visible only after that edge.
- R3: The octave field (word bits [13:11]) is never changed by vibrato. The unmasked increment is `(mfn << 5) >> (7 - octave)`, where `mfn` is the 12-bit modulated frequency number.
- R4: With vibrato active, `mfn = ((fnum << 1) + offset) mod 4096`, where `fnum` is word bits [10:0] and the offset is a signed two's-complement value. Overflow and underflow wrap inside the 12 bits.
- R5: The operator's signed detune value is added to the increment, and the sum is kept modulo 2^17.
- R6: The multiplier code M gives a factor of 1 when M = 0 and 2M otherwise. The increment added to the accumulator is `(sum * factor) >> 1`.
- R7: When the sensitivity `vib_sens` is zero, or the operator's offset is zero, that operator adds its supplied unmodulated increment `base_inc` unchanged.
- R8: With `split_en` high, operator 0 uses alternate word 1, operator 1 uses alternate word 2, operator 2 uses alternate word 0, and operator 3 uses `ch_word`. The alternate words are packed at bits [k*14 +: 14]. The row address of operator k is its word's bits [10:4], output at `vib_row[k*7 +: 7]`.
- R9: With `split_en` low, all four operators use `ch_word`.
- R10: `det_key` always equals `key_code`, whatever the vibrato inputs are.
- R11: Accumulators wrap modulo 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One-cycle strobe that advances all accumulators |
| split_en | input | 1 | Selects per-operator frequency words |
| ch_word | input | 14 | Channel octave/frequency word |
| alt_words | input | 42 | Three alternate words, word k at [k*14 +: 14] |
| key_code | input | 5 | Stored keyscale code |
| vib_sens | input | 3 | Vibrato sensitivity; zero disables vibrato |
| vib_ofs | input | 32 | Signed vibrato offset per operator, [k*8 +: 8] |
| det_ofs | input | 24 | Signed detune value per operator, [k*6 +: 6] |
| mul_code | input | 16 | Multiplier code per operator, [k*4 +: 4] |
| base_inc | input | 80 | Unmodulated increment per operator, [k*20 +: 20] |
| vib_row | output | 28 | Depth-table row address per operator, [k*7 +: 7] |
| det_key | output | 5 | Keyscale code for the detune lookup |
| phase | output | 80 | Accumulators, operator k at [k*20 +: 20] |

## Verification
Several behaviours are checked by assertions on every cycle: the hold and advance rule of the accumulators, the clear under reset, the word routing in both modes (seen through the row addresses), and the fall-back to the supplied increment when sensitivity is zero. The arithmetic of the modulated path can only be shown by the bench's scenarios, which compare accumulator values against a bench-side model. This covers 12-bit wrap of the modulated frequency number, octave preservation, detune masking, the multiplier encoding and 20-bit wrap of the accumulators.

// File: rtl/fm_pg_pkg.sv
package fm_pg_pkg;
    localparam int NUM_OPS = 4;
    localparam int NUM_ALT = 3;

    // Source of each operator's word in split mode; NUM_ALT means the channel word.
    function automatic int unsigned split_src(input int unsigned op);
        case (op)
            0:       return 1;
            1:       return 2;
            2:       return 0;
            default: return NUM_ALT;
        endcase
    endfunction
endpackage

// File: rtl/fm_pg_route.sv
module fm_pg_route
    import fm_pg_pkg::*;
#(
    parameter int WORD_W = 14
) (
    input  logic                        split_en,
    input  logic [WORD_W-1:0]           ch_word,
    input  logic [NUM_ALT*WORD_W-1:0]   alt_words,
    output logic [NUM_OPS*WORD_W-1:0]   op_words
);
    for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
        localparam int unsigned SRC = split_src(op);
        if (SRC < NUM_ALT) begin : g_alt
            always_comb begin
                op_words[op*WORD_W +: WORD_W] = split_en ? alt_words[SRC*WORD_W +: WORD_W] : ch_word;
            end
        end else begin : g_own
            always_comb begin
                op_words[op*WORD_W +: WORD_W] = ch_word;
            end
        end
    end
endmodule

// File: rtl/fm_pg_incr.sv
module fm_pg_incr #(
    parameter int WORD_W = 14,
    parameter int FN_W   = 11,
    parameter int OFS_W  = 8,
    parameter int DET_W  = 6,
    parameter int MUL_W  = 4,
    parameter int SENS_W = 3,
    parameter int ACC_W  = 20
) (
    input  logic [WORD_W-1:0] word,
    input  logic [SENS_W-1:0] vib_sens,
    input  logic [OFS_W-1:0]  vib_ofs,
    input  logic [DET_W-1:0]  det_ofs,
    input  logic [MUL_W-1:0]  mul_code,
    input  logic [ACC_W-1:0]  base_inc,
    output logic [FN_W-5:0]   row,
    output logic [ACC_W-1:0]  inc
);
    localparam int BLK_W  = WORD_W - FN_W;
    localparam int MFN_W  = FN_W + 1;
    localparam int INC_W  = MFN_W + 5;
    localparam int PROD_W = INC_W + MUL_W + 1;

    logic [FN_W-1:0]   fnum;
    logic [BLK_W-1:0]  octave;
    logic [BLK_W-1:0]  shamt;
    logic [FN_W+1:0]   mfn_sum;
    logic [MFN_W-1:0]  mfn;
    logic [INC_W-1:0]  shifted;
    logic [INC_W-1:0]  finc;
    logic [MUL_W:0]    factor;
    logic [PROD_W-1:0] prod;
    logic              vib_on;

    always_comb begin
        fnum    = word[FN_W-1:0];
        octave  = word[WORD_W-1:FN_W];
        row     = fnum[FN_W-1:4];
        vib_on  = (vib_sens != '0) && (vib_ofs != '0);
        // 12-bit modulated frequency number; octave stays untouched
        mfn_sum = {1'b0, fnum, 1'b0} + {{(FN_W+2-OFS_W){vib_ofs[OFS_W-1]}}, vib_ofs};
        mfn     = mfn_sum[MFN_W-1:0];
        shamt   = {BLK_W{1'b1}} - octave;
        shifted = {mfn, 5'b0} >> shamt;
        finc    = shifted + {{(INC_W-DET_W){det_ofs[DET_W-1]}}, det_ofs};
        factor  = (mul_code == '0) ? (MUL_W+1)'(1) : {mul_code, 1'b0};
        prod    = PROD_W'(finc) * PROD_W'(factor);
        inc     = vib_on ? ACC_W'(prod >> 1) : base_inc;
    end
endmodule

// File: rtl/fm_phase_gen.sv
module fm_phase_gen
    import fm_pg_pkg::*;
#(
    parameter int WORD_W = 14,
    parameter int FN_W   = 11,
    parameter int OFS_W  = 8,
    parameter int DET_W  = 6,
    parameter int MUL_W  = 4,
    parameter int SENS_W = 3,
    parameter int KC_W   = 5,
    parameter int ACC_W  = 20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sample_stb,
    input  logic                        split_en,
    input  logic [WORD_W-1:0]           ch_word,
    input  logic [NUM_ALT*WORD_W-1:0]   alt_words,
    input  logic [KC_W-1:0]             key_code,
    input  logic [SENS_W-1:0]           vib_sens,
    input  logic [NUM_OPS*OFS_W-1:0]    vib_ofs,
    input  logic [NUM_OPS*DET_W-1:0]    det_ofs,
    input  logic [NUM_OPS*MUL_W-1:0]    mul_code,
    input  logic [NUM_OPS*ACC_W-1:0]    base_inc,
    output logic [NUM_OPS*(FN_W-4)-1:0] vib_row,
    output logic [KC_W-1:0]             det_key,
    output logic [NUM_OPS*ACC_W-1:0]    phase
);
    localparam int ROW_W = FN_W - 4;

    typedef struct packed {
        logic [NUM_OPS*ACC_W-1:0] phase;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_OPS*WORD_W-1:0] op_words;
    logic [NUM_OPS*ACC_W-1:0]  op_inc;

    // Detune is indexed by the stored code only; vibrato has no path here.
    assign det_key = key_code;

    fm_pg_route #(.WORD_W(WORD_W)) route_i (
        .split_en  (split_en),
        .ch_word   (ch_word),
        .alt_words (alt_words),
        .op_words  (op_words)
    );

    for (genvar op = 0; op < NUM_OPS; op++) begin : g_inc
        fm_pg_incr #(
            .WORD_W(WORD_W), .FN_W(FN_W), .OFS_W(OFS_W), .DET_W(DET_W),
            .MUL_W(MUL_W), .SENS_W(SENS_W), .ACC_W(ACC_W)
        ) incr_i (
            .word     (op_words[op*WORD_W +: WORD_W]),
            .vib_sens (vib_sens),
            .vib_ofs  (vib_ofs[op*OFS_W +: OFS_W]),
            .det_ofs  (det_ofs[op*DET_W +: DET_W]),
            .mul_code (mul_code[op*MUL_W +: MUL_W]),
            .base_inc (base_inc[op*ACC_W +: ACC_W]),
            .row      (vib_row[op*ROW_W +: ROW_W]),
            .inc      (op_inc[op*ACC_W +: ACC_W])
        );

        AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
            sample_stb |=> phase[op*ACC_W +: ACC_W] ==
                           $past(phase[op*ACC_W +: ACC_W] + op_inc[op*ACC_W +: ACC_W])); // R2

        AST_QUIET_INC: assert property (@(posedge clk) disable iff (!rst_n)
            (vib_sens == '0) |-> op_inc[op*ACC_W +: ACC_W] == base_inc[op*ACC_W +: ACC_W]); // R7

        AST_PLAIN_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
            !split_en |-> vib_row[op*ROW_W +: ROW_W] == ch_word[FN_W-1:4]); // R9
    end

    always_comb begin
        st_d = st_q;
        if (sample_stb) begin
            for (int op = 0; op < NUM_OPS; op++) begin
                st_d.phase[op*ACC_W +: ACC_W] = st_q.phase[op*ACC_W +: ACC_W] + op_inc[op*ACC_W +: ACC_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase = st_q.phase;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> phase == '0); // R1

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(phase)); // R2

    AST_SPLIT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        split_en |-> (vib_row[0*ROW_W +: ROW_W] == alt_words[1*WORD_W+4 +: ROW_W]) &&
                     (vib_row[1*ROW_W +: ROW_W] == alt_words[2*WORD_W+4 +: ROW_W]) &&
                     (vib_row[2*ROW_W +: ROW_W] == alt_words[0*WORD_W+4 +: ROW_W]) &&
                     (vib_row[3*ROW_W +: ROW_W] == ch_word[FN_W-1:4])); // R8
endmodule

// File: tb/fm_phase_gen_tb.sv
module fm_phase_gen_tb_top;
    localparam int W = 14, OW = 8, DW = 6, MW = 4, AW = 20, RW = 7, KW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_stb = 1'b0;
    logic split_en = 1'b0;
    logic [W-1:0]    ch_word = '0;
    logic [3*W-1:0]  alt_words = '0;
    logic [KW-1:0]   key_code = '0;
    logic [2:0]      vib_sens = '0;
    logic [4*OW-1:0] vib_ofs = '0;
    logic [4*DW-1:0] det_ofs = '0;
    logic [4*MW-1:0] mul_code = '0;
    logic [4*AW-1:0] base_inc = '0;
    logic [4*RW-1:0] vib_row;
    logic [KW-1:0]   det_key;
    logic [4*AW-1:0] phase;

    int n_tests = 0;
    int n_fail = 0;
    logic [AW-1:0] exp_ph [4];

    always #4 clk = ~clk;

    fm_phase_gen dut_i (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .split_en(split_en),
        .ch_word(ch_word), .alt_words(alt_words), .key_code(key_code),
        .vib_sens(vib_sens), .vib_ofs(vib_ofs), .det_ofs(det_ofs),
        .mul_code(mul_code), .base_inc(base_inc), .vib_row(vib_row),
        .det_key(det_key), .phase(phase)
    );

    function automatic logic [W-1:0] word_of(input int op);
        int src;
        if (!split_en || op == 3) return ch_word;
        src = (op == 0) ? 1 : (op == 1) ? 2 : 0;
        return alt_words[src*W +: W];
    endfunction

    function automatic logic [AW-1:0] model_inc(input int op);
        int fn, oct, ofs, det, mc, m, b, f, fac;
        logic [W-1:0] wd;
        wd  = word_of(op);
        fn  = int'(wd[10:0]);
        oct = int'(wd[13:11]);
        ofs = int'($signed(vib_ofs[op*OW +: OW]));
        det = int'($signed(det_ofs[op*DW +: DW]));
        mc  = int'(mul_code[op*MW +: MW]);
        if (vib_sens == 0 || ofs == 0) return base_inc[op*AW +: AW];
        m   = (fn * 2 + ofs) & 32'hfff;
        b   = (m * 32) >> (7 - oct);
        f   = (b + det) & 32'h1ffff;
        fac = (mc == 0) ? 1 : 2 * mc;
        return AW'(((f * fac) >> 1) & 32'hfffff);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic strobe_and_check(input string req);
        logic [AW-1:0] inc [4];
        for (int op = 0; op < 4; op++) inc[op] = model_inc(op);
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        for (int op = 0; op < 4; op++) begin
            exp_ph[op] = exp_ph[op] + inc[op];
            chk(req, 32'(phase[op*AW +: AW]), 32'(exp_ph[op]));
        end
    endtask

    task automatic set_all(input logic [7:0] ofs, input logic [5:0] det, input logic [3:0] mc);
        for (int op = 0; op < 4; op++) begin
            vib_ofs[op*OW +: OW]  = ofs;
            det_ofs[op*DW +: DW]  = det;
            mul_code[op*MW +: MW] = mc;
        end
    endtask

    task automatic randomize_inputs();
        ch_word   = W'($urandom);
        alt_words = {W'($urandom), W'($urandom), W'($urandom)};
        key_code  = KW'($urandom);
        vib_sens  = (($urandom % 4) == 0) ? 3'd0 : 3'($urandom);
        split_en  = 1'($urandom);
        for (int op = 0; op < 4; op++) begin
            vib_ofs[op*OW +: OW]  = (($urandom % 5) == 0) ? 8'd0 : 8'($urandom);
            det_ofs[op*DW +: DW]  = DW'($urandom);
            mul_code[op*MW +: MW] = MW'($urandom);
            base_inc[op*AW +: AW] = AW'($urandom);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int op = 0; op < 4; op++) exp_ph[op] = '0;
        sample_stb = 1'b1;
        vib_sens = 3'd1; set_all(8'd3, 6'd1, 4'd1); base_inc = {4{20'h12345}};
        repeat (3) @(negedge clk);
        for (int op = 0; op < 4; op++) chk("R1 reset clear", 32'(phase[op*AW +: AW]), 0);
        sample_stb = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R4: overflow of the 12-bit number must not touch the octave
        ch_word = {3'd3, 11'h7ff}; vib_sens = 3'd2; set_all(8'd5, 6'd0, 4'd1);
        strobe_and_check("R3 R4 overflow keeps octave");
        chk("R4 overflow inc", 32'(phase[0 +: AW]), 32'(exp_ph[0]));
        // R4: underflow at octave 7
        ch_word = {3'd7, 11'h000}; set_all(8'hff, 6'd31, 4'd1);
        strobe_and_check("R4 underflow wraps to 0xfff");
        // R5/R6: negative detune masked; multiplier code 0 halves
        ch_word = {3'd0, 11'h000}; set_all(8'd1, 6'h3f, 4'd0);
        strobe_and_check("R5 R6 detune mask and mul 0");
        // R6: max multiplier
        ch_word = {3'd5, 11'h3a5}; set_all(8'hf0, 6'd7, 4'd15);
        strobe_and_check("R6 mul 15");
        // R7: sensitivity zero uses supplied increment despite offset
        vib_sens = 3'd0; set_all(8'd9, 6'd3, 4'd2);
        base_inc = {20'h00011, 20'h00022, 20'h00033, 20'h00044};
        strobe_and_check("R7 sens zero");
        // R7: offset zero with nonzero sensitivity
        vib_sens = 3'd4; set_all(8'd0, 6'd3, 4'd2);
        strobe_and_check("R7 offset zero");
        // R11: accumulator wrap
        vib_sens = 3'd0; base_inc = {4{20'hfffff}};
        strobe_and_check("R11 wrap");
        base_inc = {4{20'h80001}};
        strobe_and_check("R11 wrap");
        // R2: no strobe, phases hold
        repeat (3) @(negedge clk);
        for (int op = 0; op < 4; op++) chk("R2 hold", 32'(phase[op*AW +: AW]), 32'(exp_ph[op]));
        // R10: keyscale code unaffected by vibrato
        key_code = 5'd19; vib_sens = 3'd7; set_all(8'h80, 6'd0, 4'd1);
        @(negedge clk);
        chk("R10 det_key", 32'(det_key), 32'd19);
        // R8: split routing
        split_en = 1'b1; ch_word = {3'd2, 11'h1f0};
        alt_words = {{3'd4, 11'h070}, {3'd6, 11'h3c0}, {3'd1, 11'h600}};
        set_all(8'd2, 6'd1, 4'd3);
        @(negedge clk);
        for (int op = 0; op < 4; op++) chk("R8 split row", 32'(vib_row[op*RW +: RW]), 32'(word_of(op) >> 4) & 32'h7f);
        strobe_and_check("R8 split increments");
        // R9: plain routing
        split_en = 1'b0;
        @(negedge clk);
        for (int op = 0; op < 4; op++) chk("R9 plain row", 32'(vib_row[op*RW +: RW]), 32'(ch_word[10:4]));
        strobe_and_check("R9 plain increments");

        for (int it = 0; it < 300; it++) begin
            randomize_inputs();
            @(negedge clk);
            for (int op = 0; op < 4; op++) chk("R8 R9 random row", 32'(vib_row[op*RW +: RW]), 32'(word_of(op) >> 4) & 32'h7f);
            chk("R10 random det_key", 32'(det_key), 32'(key_code));
            for (int op = 0; op < 4; op++) chk("R2 random hold", 32'(phase[op*AW +: AW]), 32'(exp_ph[op]));
            strobe_and_check("R3 R4 R5 R6 R7 random advance");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule